// File: doc/BRIEF.md
# LCD Display Timing Generator

This block turns a display clock into the timing that a dot-matrix LCD driver needs. Each display clock tick produces a one-cycle line strobe for the display data latch. It also advances a line address that selects which RAM row the latch reads. The line address wraps after a set number of lines, and each wrap closes one frame. The frame-rate AC inversion signal flips on every wrap, so its polarity repeats every two frames. A display-off control, active low, goes out beside it. Display reads run on this timing alone and never wait on host RAM accesses.

Two mode straps set how the block works. The master strap chooses whether this chip generates timing or follows another chip. The oscillator strap chooses, for a master only, whether the display clock is the internal oscillator tick or a rising edge on the external clock pin. A master drives the frame signal and the display-off pin. It also drives the clock pin when it runs from its own oscillator. A slave takes all three pins as inputs. A slave keeps no frame counter of its own: it restarts its line count whenever it sees a new frame polarity from the master. The whole block runs on one system clock. Clock-pin edges and all slave inputs pass through two-flop synchronisers.

Top module: `lcd_timing_gen`

## Requirements
- R1: While reset is asserted and after its release with no tick, `line_addr` is 0, `fr` is 0, `line_strobe` and `cl_out` are 0, and `blank` is 1.
- R2: The display tick is `osc_tick` when `strap_master`=1 and `strap_int_osc`=1. In every other strap combination it is a rising edge of `cl_in`, which moves `line_addr` on the third system clock edge after `cl_in` rises. The tick source that is not selected has no effect.
- R3: `fr_oe` and `dof_oe` equal `strap_master`. `cl_oe` is 1 only when both straps are 1. When a pin is not driven, its `*_out` value is 0.
- R4: Every display tick gives exactly one cycle of `line_strobe`=1, in the same cycle that `line_addr` takes its new value. With the internal oscillator selected, `cl_out` pulses in that same cycle. Without a tick, `line_addr` holds.
- R5: `line_addr` counts 0, 1, … LINES-1 and then returns to 0, including when LINES is not a power of two.
- R6: In master mode, `fr` toggles at exactly the tick that wraps `line_addr` to 0, and at no other time. `fr_out` equals `fr`.
- R7: In master mode, `dof_out_n` takes the value of `display_on` at each tick and holds between ticks. `blank` is the inverse of `dof_out_n`.
- R8: In slave mode, a tick whose synchronised `fr_in` differs from the current `fr` sets `line_addr` to 0 and `fr` to the new value. A tick with an unchanged `fr_in` counts and wraps normally, without ever toggling `fr`. An `fr_in` change that arrives without a tick leaves `fr` and `line_addr` unchanged until the next tick.
- R9: In slave mode, `blank` equals the inverse of `dof_in_n` two system clocks after it changes.

Ports in the order of the port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strap_master | input | 1 | 1 = master (drives timing pins), 0 = slave |
| strap_int_osc | input | 1 | 1 = internal oscillator selected (master only) |
| osc_tick | input | 1 | One-cycle pulse per internal oscillator period |
| display_on | input | 1 | Display enable from the command logic (master) |
| cl_in | input | 1 | External display clock pin value |
| fr_in | input | 1 | Frame polarity from the master (slave) |
| dof_in_n | input | 1 | Display-off from the master, active low (slave) |
| cl_out | output | 1 | Display clock pulse out (master, internal oscillator) |
| cl_oe | output | 1 | Clock pin output enable |
| fr_out | output | 1 | Frame polarity pin drive |
| fr_oe | output | 1 | Frame pin output enable |
| dof_out_n | output | 1 | Display-off pin drive, active low |
| dof_oe | output | 1 | Display-off pin output enable |
| line_strobe | output | 1 | Latch strobe, one cycle per display tick |
| line_addr | output | $clog2(LINES) | Current display line address |
| fr | output | 1 | Frame polarity in effect |
| blank | output | 1 | 1 = display forced off |

## Verification
In slave mode, a frame polarity change and a clock edge can arrive in the same system cycle. In that case the realignment to line 0 must win over the normal increment. The bench provokes this by moving `fr_in` and `cl_in` together through identical synchronisers, and separately by changing `fr_in` several cycles before the next clock edge. In both cases it judges `line_addr` and `fr` at the cycle the tick lands against a reference model. In master mode, the wrap to line 0 and the frame toggle share one tick; this is checked against the same model for a line count that is not a power of two.

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen #(
  parameter int LINES = 64,
  localparam int AW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strap_master,
  input  logic          strap_int_osc,
  input  logic          osc_tick,
  input  logic          display_on,
  input  logic          cl_in,
  input  logic          fr_in,
  input  logic          dof_in_n,
  output logic          cl_out,
  output logic          cl_oe,
  output logic          fr_out,
  output logic          fr_oe,
  output logic          dof_out_n,
  output logic          dof_oe,
  output logic          line_strobe,
  output logic [AW-1:0] line_addr,
  output logic          fr,
  output logic          blank
);

  localparam logic [AW-1:0] LAST = AW'(LINES - 1);

  logic       int_mode, tick, wrap, fr_new;
  logic [2:0] cl_sync;
  logic [1:0] fr_sync, dof_sync;
  logic       fr_q, dofn_q, cl_pulse;

  assign int_mode = strap_master & strap_int_osc;
  assign tick     = int_mode ? osc_tick : (cl_sync[1] & ~cl_sync[2]);
  assign wrap     = (line_addr == LAST);
  assign fr_new   = ~strap_master & (fr_sync[1] != fr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cl_sync  <= '0;
      fr_sync  <= '0;
      dof_sync <= '0;
    end else begin
      cl_sync  <= {cl_sync[1:0], cl_in};
      fr_sync  <= {fr_sync[0], fr_in};
      dof_sync <= {dof_sync[0], dof_in_n};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_addr   <= '0;
      fr_q        <= 1'b0;
      dofn_q      <= 1'b0;
      line_strobe <= 1'b0;
      cl_pulse    <= 1'b0;
    end else begin
      line_strobe <= tick;
      cl_pulse    <= tick & int_mode;
      if (tick) begin
        if (fr_new) begin
          line_addr <= '0;
          fr_q      <= fr_sync[1];
        end else begin
          line_addr <= wrap ? '0 : line_addr + 1'b1;
          if (strap_master && wrap) fr_q <= ~fr_q;
        end
        if (strap_master) dofn_q <= display_on;
      end
    end
  end

  assign cl_oe     = int_mode;
  assign cl_out    = cl_pulse;
  assign fr_oe     = strap_master;
  assign fr_out    = strap_master & fr_q;
  assign dof_oe    = strap_master;
  assign dof_out_n = strap_master & dofn_q;
  assign fr        = fr_q;
  assign blank     = strap_master ? ~dofn_q : ~dof_sync[1];

endmodule

// File: rtl/lcd_timing_gen_chk.sv
module lcd_timing_gen_chk #(
  parameter int LINES = 64,
  localparam int AW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          strap_master,
  input logic          strap_int_osc,
  input logic          osc_tick,
  input logic          line_strobe,
  input logic [AW-1:0] line_addr,
  input logic          fr,
  input logic          dof_out_n
);

  localparam logic [AW-1:0] LAST = AW'(LINES - 1);

  p_osc_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    line_strobe && strap_master && strap_int_osc |-> $past(osc_tick));

  p_hold_no_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !line_strobe |-> line_addr == $past(line_addr));

  p_addr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    line_addr <= LAST);

  p_fr_at_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strap_master && (fr != $past(fr)) |-> line_strobe && line_addr == '0);

  p_dof_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strap_master && !line_strobe |-> $stable(dof_out_n));

  p_slave_realign_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_master && (fr != $past(fr)) |-> line_strobe && line_addr == '0);

endmodule

bind lcd_timing_gen lcd_timing_gen_chk #(.LINES(LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .strap_master(strap_master),
  .strap_int_osc(strap_int_osc), .osc_tick(osc_tick),
  .line_strobe(line_strobe), .line_addr(line_addr), .fr(fr),
  .dof_out_n(dof_out_n)
);

// File: tb/lcd_timing_gen_tb.sv
`timescale 1ns/1ps
module lcd_timing_gen_tb;
  localparam int LINES = 10;
  localparam int AW = $clog2(LINES);

  logic clk = 0, rst_n = 0;
  logic strap_master = 1, strap_int_osc = 1, osc_tick = 0, display_on = 0;
  logic cl_in = 0, fr_in = 0, dof_in_n = 0;
  logic cl_out, cl_oe, fr_out, fr_oe, dof_out_n, dof_oe, line_strobe, fr, blank;
  logic [AW-1:0] line_addr;

  int checks = 0, failures = 0;
  bit done = 0;
  int m_addr; bit m_fr, m_dofn;

  always #10 clk = ~clk;

  lcd_timing_gen #(.LINES(LINES)) u_dut (.*);

  function automatic int next_addr(int a);
    return (a == LINES - 1) ? 0 : a + 1;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_state(string req, bit strobe_exp);
    chk(line_addr == AW'(m_addr), {req, " addr"}, line_addr, m_addr);
    chk(fr == m_fr, {req, " fr"}, fr, m_fr);
    chk(line_strobe == strobe_exp, "R4 strobe", line_strobe, strobe_exp);
  endtask

  task automatic do_reset(bit ms, bit io);
    @(negedge clk);
    rst_n = 0; strap_master = ms; strap_int_osc = io;
    osc_tick = 0; cl_in = 0; fr_in = 0; dof_in_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_addr = 0; m_fr = 0; m_dofn = 0;
    @(negedge clk);
    check_state("R1", 0);
    chk(blank == 1, "R1 blank", blank, 1);
    chk(cl_out == 0, "R1 cl_out", cl_out, 0);
    chk(fr_oe == ms && dof_oe == ms, "R3 fr/dof oe", {fr_oe, dof_oe}, {ms, ms});
    chk(cl_oe == (ms & io), "R3 cl_oe", cl_oe, ms & io);
  endtask

  task automatic master_tick_model(bit don);
    m_dofn = don;
    if (m_addr == LINES - 1) m_fr = ~m_fr;
    m_addr = next_addr(m_addr);
  endtask

  task automatic tick_int(bit don);
    osc_tick = 1; display_on = don;
    @(negedge clk);
    osc_tick = 0;
    master_tick_model(don);
    check_state("R5/R6", 1);
    chk(cl_out == 1, "R4 cl_out", cl_out, 1);
    chk(fr_out == m_fr, "R6 fr_out", fr_out, m_fr);
    chk(dof_out_n == m_dofn && blank == !m_dofn, "R7 dof", {dof_out_n, blank}, {m_dofn, !m_dofn});
  endtask

  task automatic tick_ext(bit frv, bit don);
    cl_in = 1; fr_in = frv; display_on = don;
    repeat (3) @(negedge clk);
    if (strap_master) master_tick_model(don);
    else if (frv != m_fr) begin m_addr = 0; m_fr = frv; end
    else m_addr = next_addr(m_addr);
    check_state(strap_master ? "R2/R6" : "R8", 1);
    chk(cl_out == 0, "R4 cl_out ext", cl_out, 0);
    if (strap_master) chk(dof_out_n == m_dofn, "R7 dof ext", dof_out_n, m_dofn);
    cl_in = 0;
    @(negedge clk);
    check_state("R4 single", 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset(1, 1);
    for (int i = 0; i < 120; i++) begin
      tick_int(1'($urandom));
      for (int g = 0; g < int'($urandom % 3); g++) begin
        @(negedge clk);
        check_state("R4 hold", 0);
      end
    end
    // clock pin ignored while oscillator selected
    cl_in = 1; repeat (4) @(negedge clk); cl_in = 0; repeat (3) @(negedge clk);
    check_state("R2 cl ignored", 0);

    do_reset(1, 0);
    for (int i = 0; i < 25; i++) tick_ext(1'($urandom), 1'($urandom));
    osc_tick = 1; @(negedge clk); osc_tick = 0; repeat (2) @(negedge clk);
    check_state("R2 osc ignored", 0);

    do_reset(0, 1);
    chk(fr_out == 0 && dof_out_n == 0 && cl_out == 0, "R3 slave outs", {fr_out, dof_out_n, cl_out}, 0);
    osc_tick = 1; @(negedge clk); osc_tick = 0; repeat (2) @(negedge clk);
    check_state("R2 slave osc ignored", 0);
    for (int i = 0; i < 13; i++) tick_ext(m_fr, 0);
    // collision: FR change and CL edge together
    tick_ext(~m_fr, 0);
    chk(line_addr == 0, "R8 collision", line_addr, 0);
    tick_ext(m_fr, 0);
    // FR change without tick stays pending
    fr_in = ~m_fr; repeat (5) @(negedge clk);
    check_state("R8 pending", 0);
    tick_ext(fr_in, 0);
    chk(line_addr == 0 && fr == fr_in, "R8 pending applied", line_addr, 0);
    for (int i = 0; i < 30; i++) tick_ext(($urandom % 4 == 0) ? ~m_fr : m_fr, 0);
    dof_in_n = 1; repeat (2) @(negedge clk);
    chk(blank == 0, "R9 on", blank, 0);
    dof_in_n = 0; repeat (2) @(negedge clk);
    chk(blank == 1, "R9 off", blank, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule